// File: doc/BRIEF.md
# Sample-Strobed Pseudo-Random Noise Source

This block makes a pseudo-random noise stimulus for test benches and on-chip signal generators. It holds a 40-stage linear feedback shift register. The register moves one step when the sample strobe is present and the enable is high. It does not move on every clock. The feedback is the inverse of the XOR of four taps. With that feedback, the all-zero word is a legal state, so reset can clear the register. The all-ones word is the state that would lock the register up. The sequence from reset is maximal length, so it repeats after 2^40−1 accepted strobes. At a 50 kHz strobe rate that is roughly eight months of samples.

Three outputs follow the register. The first is a signed 10-bit noise word whose size is a quarter of a full-scale ±511 tone. The second is the raw bit at the register's output end. The third is a one-clock valid flag that marks each step. Between strobes all three outputs hold still. The register's clear is applied asynchronously. It is released on the clock through a small synchronizer.

Top module: `strobed_noise_src`

## Requirements
- R1: While `rst_n` is low, and for the release cycles that follow it, `noise_word` is 0, `noise_bit` is 0 and `noise_vld` is 0. Strobes seen during that time do not advance the register. The register restarts from the all-zero word, and the first strobe is accepted on the third rising edge after `rst_n` rises.
- R2: A clock edge with `sample_stb`=1 and `run_en`=1 shifts the 40-bit register by one place toward its top. Bit k+1 takes the old bit k, and bit 0 takes the feedback bit.
- R3: The feedback bit is NOT(s[39] XOR s[37] XOR s[20] XOR s[18]), with bits numbered 0 to 39. Starting from all zeros, the first accepted step writes a 1 into bit 0. The register never holds the all-ones word.
- R4: On a clock edge without an accepted strobe, `noise_word` and `noise_bit` keep their values.
- R5: When `run_en` is 0, a strobe is ignored. The register does not move and `noise_vld` stays 0.
- R6: `noise_vld` is 1 in exactly the clock cycle that follows each accepted strobe edge. Strobes on consecutive edges give consecutive valid cycles.
- R7: `noise_word` is register bits 39..32 read as an 8-bit two's-complement number and sign-extended to 10 bits. Its value therefore always lies in −128..127.
- R8: `noise_bit` equals register bit 39. This is the same bit as the sign bit of `noise_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| sample_stb | input | 1 | Sample strobe; one register step per strobed edge |
| run_en | input | 1 | Enable; a strobe is ignored while this is low |
| noise_word | output | 10 | Signed noise sample, range −128..127 |
| noise_bit | output | 1 | Raw serial bit from the register's top stage |
| noise_vld | output | 1 | One-cycle flag after each register step |

## Verification
A wrong tap or a missing inversion leaves the top byte correct at first, because the early steps only fill the low stages. The error shows on `noise_word` and `noise_bit` once the bad feedback bit has moved up to stage 32. That happens within about 33 accepted strobes of reset. A step taken at the wrong time, for example on an idle edge or with the enable low, shows at once. The outputs change when they should hold, or `noise_vld` rises without an accepted strobe. A lost step shows one strobe later as a sequence that lags the expected one.

// File: rtl/noise_pkg.sv
package noise_pkg;

  // Register length and output shaping defaults.
  localparam int unsigned NS_STAGES = 40;
  localparam int unsigned NS_OUT_W  = 10;
  localparam int unsigned NS_TAKE_W = 8;

  // Tap positions 39, 37, 20 and 18 (zero-based) give a maximal sequence.
  localparam logic [NS_STAGES-1:0] NS_TAP_MASK = 40'hA0_0014_0000;

  // Depth of the reset release synchronizer.
  localparam int unsigned NS_SYNC_DEPTH = 2;

endpackage

// File: rtl/noise_rst_sync.sv
module noise_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[DEPTH-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[DEPTH-1];

endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core #(
  parameter int unsigned             STAGES   = 40,
  parameter logic [STAGES-1:0]       TAP_MASK = 40'hA0_0014_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [STAGES-1:0] state_q
);

  logic              fb_bit;
  logic [STAGES-1:0] state_d;

  // Inverted parity of the tapped stages: zero word is legal, ones word locks.
  always_comb begin
    fb_bit  = ~(^(state_q & TAP_MASK));
    state_d = state_q;
    if (step) begin
      state_d = {state_q[STAGES-2:0], fb_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (step) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/noise_out_stage.sv
module noise_out_stage #(
  parameter int unsigned STAGES = 40,
  parameter int unsigned OUT_W  = 10,
  parameter int unsigned TAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [STAGES-1:0] state,
  output logic [OUT_W-1:0]  word,
  output logic              bit_out,
  output logic              vld
);

  localparam int unsigned EXT_W = OUT_W - TAKE_W;

  logic [TAKE_W-1:0] top_slice;
  logic              vld_d;
  logic              vld_q;

  assign top_slice = state[STAGES-1 -: TAKE_W];

  generate
    if (EXT_W == 0) begin : g_no_ext
      assign word = top_slice;
    end else begin : g_ext
      assign word = {{EXT_W{top_slice[TAKE_W-1]}}, top_slice};
    end
  endgenerate

  assign bit_out = state[STAGES-1];

  always_comb vld_d = step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign vld = vld_q;

endmodule

// File: rtl/strobed_noise_src.sv
module strobed_noise_src
  import noise_pkg::*;
#(
  parameter int unsigned       STAGES     = NS_STAGES,
  parameter int unsigned       OUT_W      = NS_OUT_W,
  parameter int unsigned       TAKE_W     = NS_TAKE_W,
  parameter logic [STAGES-1:0] TAP_MASK   = NS_TAP_MASK,
  parameter int unsigned       SYNC_DEPTH = NS_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic             run_en,
  output logic [OUT_W-1:0] noise_word,
  output logic             noise_bit,
  output logic             noise_vld
);

  logic              rst_sync_n;
  logic              step;
  logic [STAGES-1:0] lfsr_state;

  noise_rst_sync #(
    .DEPTH (SYNC_DEPTH)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // Clock enable for the register: strobe qualified by the run enable.
  assign step = sample_stb & run_en;

  noise_lfsr_core #(
    .STAGES   (STAGES),
    .TAP_MASK (TAP_MASK)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (step),
    .state_q (lfsr_state)
  );

  noise_out_stage #(
    .STAGES (STAGES),
    .OUT_W  (OUT_W),
    .TAKE_W (TAKE_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (step),
    .state   (lfsr_state),
    .word    (noise_word),
    .bit_out (noise_bit),
    .vld     (noise_vld)
  );

endmodule

// File: rtl/noise_src_chk.sv
module noise_src_chk #(
  parameter int unsigned       STAGES   = 40,
  parameter int unsigned       OUT_W    = 10,
  parameter int unsigned       TAKE_W   = 8,
  parameter logic [STAGES-1:0] TAP_MASK = 40'hA0_0014_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb,
  input logic              en,
  input logic [STAGES-1:0] state,
  input logic [OUT_W-1:0]  noise_word,
  input logic              noise_bit,
  input logic              noise_vld
);

  localparam int unsigned HI_W = OUT_W - TAKE_W + 1;

  AST_STEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> noise_vld); // R6

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && en) |=> !noise_vld); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && en) |=> ($stable(noise_word) && $stable(noise_bit))); // R4

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> (state[STAGES-1:1] == $past(state[STAGES-2:0]))); // R2

  AST_FEEDBACK_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en) |=> (state[0] == ~(^($past(state) & TAP_MASK)))); // R3

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
    state != '1); // R3

  AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_word[OUT_W-1 -: HI_W] == '0) || (noise_word[OUT_W-1 -: HI_W] == '1)); // R7

  AST_BIT_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    noise_bit == noise_word[OUT_W-1]); // R8

endmodule

bind strobed_noise_src noise_src_chk #(
  .STAGES   (STAGES),
  .OUT_W    (OUT_W),
  .TAKE_W   (TAKE_W),
  .TAP_MASK (TAP_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .stb        (sample_stb),
  .en         (run_en),
  .state      (lfsr_state),
  .noise_word (noise_word),
  .noise_bit  (noise_bit),
  .noise_vld  (noise_vld)
);

// File: tb/test_strobed_noise_src.sv
`timescale 1ns/1ps
module test_strobed_noise_src;

  logic       clk;
  logic       rst_n;
  logic       sample_stb;
  logic       run_en;
  logic [9:0] noise_word;
  logic       noise_bit;
  logic       noise_vld;

  int n_cmp;
  int n_bad;
  bit done;

  logic [39:0] model;
  logic        exp_vld;

  strobed_noise_src i_strobed_noise_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .run_en     (run_en),
    .noise_word (noise_word),
    .noise_bit  (noise_bit),
    .noise_vld  (noise_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [39:0] next_of(input logic [39:0] s);
    logic fb;
    fb = ~(s[39] ^ s[37] ^ s[20] ^ s[18]);
    return {s[38:0], fb};
  endfunction

  function automatic logic [9:0] word_of(input logic [39:0] s);
    return {{2{s[39]}}, s[39:32]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " word"}, {22'd0, noise_word}, {22'd0, word_of(model)});
    check({req, " bit"},  {31'd0, noise_bit},  {31'd0, model[39]});
    check({req, " vld"},  {31'd0, noise_vld},  {31'd0, exp_vld});
  endtask

  // One clock with given strobe/enable, then sample at the following negedge.
  task automatic drive(input logic s, input logic e);
    @(negedge clk);
    sample_stb = s;
    run_en     = e;
    @(negedge clk);
    if (s && e) model = next_of(model);
    exp_vld    = s && e;
    sample_stb = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sample_stb = 1'b1; run_en = 1'b1;
    model = '0; exp_vld = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 release cycle 1");
    @(negedge clk);
    check_outputs("R1 release cycle 2");
    sample_stb = 1'b0;
    @(negedge clk);
    exp_vld = 1'b0;
    check_outputs("R1 after release");
  endtask

  task automatic t_first_fill;
    for (int i = 0; i < 40; i++) begin
      drive(1'b1, 1'b1);
      check_outputs("R3 fill from zero");
    end
    check({"R3 top bit set after 40"}, {31'd0, noise_bit}, 32'd1);
  endtask

  task automatic t_long_run;
    for (int i = 0; i < 300; i++) begin
      drive(1'b1, 1'b1);
      check_outputs("R2 step");
      check("R8 bit vs sign", {31'd0, noise_bit}, {31'd0, noise_word[9]});
      check("R7 range", {31'd0, ($signed(noise_word) >= -128) && ($signed(noise_word) <= 127)}, 32'd1);
    end
  endtask

  task automatic t_idle_hold;
    logic [9:0] w0;
    logic       b0;
    w0 = noise_word; b0 = noise_bit;
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 1'b1);
      check("R4 word held", {22'd0, noise_word}, {22'd0, w0});
      check("R4 bit held",  {31'd0, noise_bit},  {31'd0, b0});
      check("R6 no flag idle", {31'd0, noise_vld}, 32'd0);
    end
  endtask

  task automatic t_disabled;
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 1'b0);
      check_outputs("R5 strobe ignored");
    end
    drive(1'b1, 1'b1);
    check_outputs("R5 resumes on same sequence");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    sample_stb = 1'b1; run_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      model = next_of(model);
      exp_vld = 1'b1;
      check_outputs("R6 consecutive");
    end
    sample_stb = 1'b0;
    @(negedge clk);
    exp_vld = 1'b0;
    check_outputs("R6 flag drops");
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    t_reset();
    t_first_fill();
    t_idle_hold();
    t_long_run();
    t_disabled();
    t_back_to_back();
    t_idle_hold();
    t_reset();
    t_first_fill();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule